// File: doc/BRIEF.md
# Keyed Restart Watchdog Timer

A memory-mapped watchdog for a system that must recover from hung software. It has a 32-bit down-counter that is refreshed only when software writes a 16-bit key to a restart register. When the counter runs out, the block requests a reset, fires a trigger toward an external pulse stage, and records the event in sticky status flags. A programmable threshold can raise an early-warning interrupt before expiry, so software gets a chance to react.

The counter steps either on every clock or only on cycles where a 1 MHz tick enable is high, chosen by a control bit. The sequencer has three states. IDLE: counting is off. RUN: the counter steps. EXPIRE: lasts one clock and carries the expiry outputs. Its transitions are: IDLE to RUN when the enable bit is set; RUN to IDLE when the enable bit is cleared; RUN to EXPIRE when a count step finds the counter at zero and no restart arrives in that cycle; EXPIRE to RUN if still enabled, or EXPIRE to IDLE if not.

Access is through a single-cycle register bus. Writes take effect at the clock edge. Read data is combinational from the address. Offsets: 0x00 live counter (read-only), 0x04 reload, 0x08 restart, 0x0C control, 0x10 status, 0x14 status clear.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the counter reads 0xFFFFFFFF, control and status read 0, and reset_req, ext_trig and irq are low.
- R2: Writing exactly 0x00004755 to offset 0x08 loads the counter from the reload register (offset 0x04) at that edge, in any state. Any other value written there leaves the counter unchanged.
- R3: The counter decrements by one per count step only while control bit 0 is 1. While it is 0, the counter holds its value.
- R4: With control bit 4 set, a count step happens only in cycles where tick_1us is high. With bit 4 clear, every clock cycle is a count step.
- R5: A count step that finds the counter at zero causes a one-clock expiry. At that point the counter reloads and status bit 0 is set; it stays set until cleared. Counting every clock, successive expiries are reload+2 cycles apart.
- R6: On expiry, reset_req pulses high for exactly one clock if control bit 1 is set, and never if it is clear. reset_scope always equals control bits 6:5 (00 SoC, 01 full chip, 10 CPU only).
- R7: On expiry, ext_trig pulses high for one clock, in the same cycle as the expiry, if control bit 3 is set, and never otherwise.
- R8: Status bit 1 (alternate boot) is set on expiry only when control bit 7 is set.
- R9: When control bit 2 is set, a count step that finds the counter equal to control bits 31:10 followed by ten zero bits sets status bit 2. irq follows status bit 2 and stays high until cleared.
- R10: Writing 1 in bit 0 to offset 0x14 clears status bits 2:0. Writing 0 in bit 0 there changes nothing.
- R11: Offsets 0x04 and 0x0C read back the written values. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1us | input | 1 | 1 MHz count-step enable |
| bus_sel | input | 1 | Bus access valid |
| bus_we | input | 1 | Write when high |
| bus_addr | input | 5 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| reset_req | output | 1 | One-clock reset request on expiry |
| reset_scope | output | 2 | Selected reset scope |
| ext_trig | output | 1 | One-clock external pulse trigger on expiry |
| irq | output | 1 | Pre-timeout interrupt, level |

## Verification
A wrong sequencer state shows at the ports in one of two ways. A stuck EXPIRE state makes reset_req stay high for a second cycle. A missed RUN entry freezes the counter value read at offset 0x00, and this is visible within a few clocks. A wrong counter load or step shows up as a wrong difference between two counter reads a known number of cycles apart, or as a wrong spacing between expiry pulses. A wrong flag update shows up in the status read and on irq in the cycle right after the event or the clear.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_EXPIRE = 2'd2
    } kwd_state_e;

    localparam int OFS_COUNT   = 'h00;
    localparam int OFS_RELOAD  = 'h04;
    localparam int OFS_RESTART = 'h08;
    localparam int OFS_CTRL    = 'h0C;
    localparam int OFS_STATUS  = 'h10;
    localparam int OFS_CLEAR   = 'h14;

    localparam logic [31:0] RESTART_KEY = 32'h0000_4755;

    localparam int CB_EN    = 0;
    localparam int CB_RST   = 1;
    localparam int CB_PRE   = 2;
    localparam int CB_EXT   = 3;
    localparam int CB_CLK1M = 4;
    localparam int CB_SCOPE = 5;
    localparam int CB_ALT   = 7;

endpackage

// File: rtl/kwd_regfile.sv
module kwd_regfile
    import kwd_pkg::*;
#(
    parameter int          CNT_W      = 32,
    parameter int          ADDR_W     = 5,
    parameter int          THR_LSB    = 10,
    parameter logic [31:0] RELOAD_RST = 32'hFFFF_FFFF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_sel,
    input  logic                     bus_we,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    input  logic [CNT_W-1:0]         cnt_val,
    input  logic [2:0]               status,
    output logic [CNT_W-1:0]         reload_q,
    output logic                     ctrl_en,
    output logic                     ctrl_rst,
    output logic                     ctrl_pre,
    output logic                     ctrl_ext,
    output logic                     ctrl_clk1m,
    output logic [1:0]               ctrl_scope,
    output logic                     ctrl_alt,
    output logic [CNT_W-THR_LSB-1:0] ctrl_thr,
    output logic                     restart_stb,
    output logic                     clear_stb
);

    logic [31:0] ctrl_q;
    logic        wr;

    assign wr = bus_sel && bus_we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= RELOAD_RST[CNT_W-1:0];
            ctrl_q   <= '0;
        end else if (wr) begin
            if (bus_addr == ADDR_W'(OFS_RELOAD)) reload_q <= bus_wdata[CNT_W-1:0];
            if (bus_addr == ADDR_W'(OFS_CTRL))   ctrl_q   <= bus_wdata;
        end
    end

    assign restart_stb = wr && (bus_addr == ADDR_W'(OFS_RESTART)) && (bus_wdata == RESTART_KEY);
    assign clear_stb   = wr && (bus_addr == ADDR_W'(OFS_CLEAR)) && bus_wdata[0];

    assign ctrl_en    = ctrl_q[CB_EN];
    assign ctrl_rst   = ctrl_q[CB_RST];
    assign ctrl_pre   = ctrl_q[CB_PRE];
    assign ctrl_ext   = ctrl_q[CB_EXT];
    assign ctrl_clk1m = ctrl_q[CB_CLK1M];
    assign ctrl_scope = ctrl_q[CB_SCOPE+1:CB_SCOPE];
    assign ctrl_alt   = ctrl_q[CB_ALT];
    assign ctrl_thr   = ctrl_q[CNT_W-1:THR_LSB];

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_W'(OFS_COUNT):  bus_rdata = 32'(cnt_val);
            ADDR_W'(OFS_RELOAD): bus_rdata = 32'(reload_q);
            ADDR_W'(OFS_CTRL):   bus_rdata = ctrl_q;
            ADDR_W'(OFS_STATUS): bus_rdata = {29'd0, status};
            default:             bus_rdata = '0;
        endcase
    end

    // R11: reload register only changes on a write to its own offset
    a_r11_reload_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && bus_addr == ADDR_W'(OFS_RELOAD)) |=> $stable(reload_q));

endmodule

// File: rtl/kwd_engine.sv
module kwd_engine
    import kwd_pkg::*;
#(
    parameter int          CNT_W      = 32,
    parameter int          THR_LSB    = 10,
    parameter logic [31:0] RELOAD_RST = 32'hFFFF_FFFF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick_1us,
    input  logic                     ctrl_en,
    input  logic                     ctrl_rst,
    input  logic                     ctrl_pre,
    input  logic                     ctrl_ext,
    input  logic                     ctrl_clk1m,
    input  logic [CNT_W-THR_LSB-1:0] ctrl_thr,
    input  logic [CNT_W-1:0]         reload,
    input  logic                     restart,
    output logic [CNT_W-1:0]         cnt,
    output logic                     expire_evt,
    output logic                     pre_hit,
    output logic                     reset_req,
    output logic                     ext_trig
);

    kwd_state_e       state, state_nxt;
    logic             step;
    logic             active;
    logic             at_zero;
    logic [CNT_W-1:0] thr_full;

    assign step     = ctrl_clk1m ? tick_1us : 1'b1;
    assign active   = (state == ST_RUN) && ctrl_en && step && !restart;
    assign at_zero  = (cnt == '0);
    assign thr_full = {ctrl_thr, {THR_LSB{1'b0}}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (ctrl_en) state_nxt = ST_RUN;
            ST_RUN: begin
                if (!ctrl_en)                state_nxt = ST_IDLE;
                else if (active && at_zero)  state_nxt = ST_EXPIRE;
            end
            ST_EXPIRE: state_nxt = ctrl_en ? ST_RUN : ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         cnt <= RELOAD_RST[CNT_W-1:0];
        else if (restart)                   cnt <= reload;
        else if (active && at_zero)         cnt <= reload;
        else if (active)                    cnt <= cnt - 1'b1;
    end

    always_comb begin
        expire_evt = (state == ST_EXPIRE);
        reset_req  = expire_evt && ctrl_rst;
        ext_trig   = expire_evt && ctrl_ext;
        pre_hit    = active && ctrl_pre && (cnt == thr_full);
    end

    // R2: a keyed restart loads the reload value
    a_r2_restart_loads: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> cnt == $past(reload));
    // R3: counter holds while disabled
    a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && !restart) |=> $stable(cnt));
    // R4: no step without a tick in tick mode
    a_r4_tick_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_clk1m && !tick_1us && !restart) |=> $stable(cnt));
    // R5: expiry lasts one clock
    a_r5_single_expire: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXPIRE) |=> (state != ST_EXPIRE));
    // R6: reset request is a single-cycle pulse
    a_r6_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);
    // R7: external trigger is a single-cycle pulse
    a_r7_trig_width: assert property (@(posedge clk) disable iff (!rst_n)
        ext_trig |=> !ext_trig);

endmodule

// File: rtl/kwd_status.sv
module kwd_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       expire_evt,
    input  logic       pre_hit,
    input  logic       alt_arm,
    input  logic       clear_stb,
    output logic [2:0] flags,
    output logic       irq
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags[0] <= (flags[0] && !clear_stb) || expire_evt;
            flags[1] <= (flags[1] && !clear_stb) || (expire_evt && alt_arm);
            flags[2] <= (flags[2] && !clear_stb) || pre_hit;
        end
    end

    assign irq = flags[2];

    // R10: a clear with no simultaneous event leaves all flags low
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_stb && !expire_evt && !pre_hit) |=> (flags == 3'b000));
    // R5: expired flag is sticky
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && !clear_stb) |=> flags[0]);
    // R9: interrupt holds until cleared
    a_r9_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clear_stb) |=> irq);

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import kwd_pkg::*;
#(
    parameter int          CNT_W      = 32,
    parameter int          ADDR_W     = 5,
    parameter int          THR_LSB    = 10,
    parameter logic [31:0] RELOAD_RST = 32'hFFFF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1us,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              reset_req,
    output logic [1:0]        reset_scope,
    output logic              ext_trig,
    output logic              irq
);

    localparam int THR_W = CNT_W - THR_LSB;

    logic [CNT_W-1:0] cnt, reload_q;
    logic [2:0]       flags;
    logic             ctrl_en, ctrl_rst, ctrl_pre, ctrl_ext, ctrl_clk1m, ctrl_alt;
    logic [THR_W-1:0] ctrl_thr;
    logic             restart_stb, clear_stb, expire_evt, pre_hit;

    kwd_regfile #(
        .CNT_W(CNT_W), .ADDR_W(ADDR_W), .THR_LSB(THR_LSB), .RELOAD_RST(RELOAD_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_val(cnt), .status(flags), .reload_q(reload_q),
        .ctrl_en(ctrl_en), .ctrl_rst(ctrl_rst), .ctrl_pre(ctrl_pre),
        .ctrl_ext(ctrl_ext), .ctrl_clk1m(ctrl_clk1m), .ctrl_scope(reset_scope),
        .ctrl_alt(ctrl_alt), .ctrl_thr(ctrl_thr),
        .restart_stb(restart_stb), .clear_stb(clear_stb)
    );

    kwd_engine #(
        .CNT_W(CNT_W), .THR_LSB(THR_LSB), .RELOAD_RST(RELOAD_RST)
    ) u_engine (
        .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us),
        .ctrl_en(ctrl_en), .ctrl_rst(ctrl_rst), .ctrl_pre(ctrl_pre),
        .ctrl_ext(ctrl_ext), .ctrl_clk1m(ctrl_clk1m), .ctrl_thr(ctrl_thr),
        .reload(reload_q), .restart(restart_stb), .cnt(cnt),
        .expire_evt(expire_evt), .pre_hit(pre_hit),
        .reset_req(reset_req), .ext_trig(ext_trig)
    );

    kwd_status u_status (
        .clk(clk), .rst_n(rst_n), .expire_evt(expire_evt), .pre_hit(pre_hit),
        .alt_arm(ctrl_alt), .clear_stb(clear_stb), .flags(flags), .irq(irq)
    );

endmodule

// File: tb/keyed_watchdog_test.sv
`timescale 1ns/1ps
module keyed_watchdog_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1us = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        reset_req, ext_trig, irq;
    logic [1:0]  reset_scope;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2 clk = ~clk;

    keyed_watchdog uut (
        .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .reset_req(reset_req), .reset_scope(reset_scope),
        .ext_trig(ext_trig), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(5'h00, v); check("R1 counter", v, 32'hFFFF_FFFF);
        rd(5'h0C, v); check("R1 ctrl", v, 32'h0);
        rd(5'h10, v); check("R1 status", v, 32'h0);
        check("R1 outputs", {29'd0, reset_req, ext_trig, irq}, 32'h0);
    endtask

    task automatic t_restart_key();
        logic [31:0] v;
        wr(5'h04, 32'd20);
        wr(5'h08, 32'h0000_4756);
        rd(5'h00, v); check("R2 wrong key ignored", v, 32'hFFFF_FFFF);
        wr(5'h08, 32'h0001_4755);
        rd(5'h00, v); check("R2 upper bits ignored", v, 32'hFFFF_FFFF);
        wr(5'h08, 32'h0000_4755);
        rd(5'h00, v); check("R2 key reloads", v, 32'd20);
        rd(5'h04, v); check("R11 reload readback", v, 32'd20);
        rd(5'h18, v); check("R11 unmapped", v, 32'h0);
    endtask

    task automatic t_enable();
        logic [31:0] a, b;
        wr(5'h04, 32'd1000);
        wr(5'h08, 32'h4755);
        wr(5'h0C, 32'h1);
        wait_cyc(2);
        rd(5'h00, a);
        wait_cyc(10);
        rd(5'h00, b);
        check("R3 ten steps", a - b, 32'd10);
        wr(5'h0C, 32'h0);
        rd(5'h00, a);
        wait_cyc(10);
        rd(5'h00, b);
        check("R3 frozen when disabled", b, a);
        wr(5'h08, 32'h4755);
        rd(5'h00, a); check("R2 restart while idle", a, 32'd1000);
    endtask

    task automatic t_tick_mode();
        logic [31:0] a, b;
        wr(5'h0C, 32'h11);
        wait_cyc(2);
        rd(5'h00, a);
        wait_cyc(10);
        rd(5'h00, b);
        check("R4 no tick no step", b, a);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); tick_1us = 1'b1;
            @(negedge clk); tick_1us = 1'b0;
            wait_cyc(2);
        end
        rd(5'h00, b);
        check("R4 three ticks", a - b, 32'd3);
        rd(5'h0C, b); check("R11 ctrl readback", b, 32'h11);
        wr(5'h0C, 32'h0);
    endtask

    task automatic t_expire_full();
        logic [31:0] v;
        int first, second, npulse, wide, mism;
        first = -1; second = -1; npulse = 0; wide = 0; mism = 0;
        wr(5'h04, 32'd5);
        wr(5'h08, 32'h4755);
        wr(5'h14, 32'h1);
        wr(5'h0C, 32'hAB);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); #1;
            if (ext_trig !== reset_req) mism++;
            if (reset_req) begin
                npulse++;
                if (first < 0) first = i;
                else if (second < 0) second = i;
            end
            if (reset_req && i > 0 && (i - 1 == first || i - 1 == second)) wide++;
        end
        check("R5 expiry count>=3", 32'(npulse >= 3), 32'd1);
        check("R5 expiry spacing", 32'(second - first), 32'd7);
        check("R6 pulse one clock", 32'(wide), 32'd0);
        check("R7 trig with expiry", 32'(mism), 32'd0);
        check("R6 scope", 32'(reset_scope), 32'd1);
        rd(5'h10, v); check("R8 status exp+alt", v, 32'h3);
        wr(5'h0C, 32'h0);
    endtask

    task automatic t_expire_quiet();
        logic [31:0] v;
        int seen;
        seen = 0;
        wr(5'h14, 32'h1);
        wr(5'h08, 32'h4755);
        wr(5'h0C, 32'h41);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk); #1;
            if (reset_req || ext_trig) seen++;
        end
        check("R6 R7 no pulses when gated", 32'(seen), 32'd0);
        check("R6 scope cpu", 32'(reset_scope), 32'd2);
        rd(5'h10, v); check("R8 no alt flag", v, 32'h1);
        wr(5'h0C, 32'h0);
        wr(5'h14, 32'h1);
        rd(5'h10, v); check("R10 clear", v, 32'h0);
    endtask

    task automatic t_pretimeout();
        logic [31:0] v;
        wr(5'h04, 32'd3000);
        wr(5'h08, 32'h4755);
        wr(5'h0C, (32'd2 << 10) | 32'h5);
        wait_cyc(5);
        check("R9 irq low early", 32'(irq), 32'd0);
        wait_cyc(1000);
        check("R9 irq after threshold", 32'(irq), 32'd1);
        rd(5'h10, v); check("R9 status bit2", v, 32'h4);
        wr(5'h14, 32'h0);
        rd(5'h10, v); check("R10 clear with bit0 low ignored", v, 32'h4);
        wr(5'h14, 32'h1);
        rd(5'h10, v); check("R10 clear status", v, 32'h0);
        check("R9 irq cleared", 32'(irq), 32'd0);
        wr(5'h0C, 32'h0);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        t_reset();
        t_restart_key();
        t_enable();
        t_tick_mode();
        t_expire_full();
        t_expire_quiet();
        t_pretimeout();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected under 100000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule